// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block holds a pair of alarm units that watch a running BCD calendar. Each unit keeps a programmed day, hour, minute and second, plus a sub-second value, and raises a sticky flag when the calendar reaches that point. Each of the four calendar fields can be masked so that it always matches. The day field can stand for either a day of the month or a day of the week. The sub-second compare can be narrowed to a chosen number of low-order bits.

The calendar counter sits outside the block. It presents its current fields together with a one-cycle update strobe, and the units compare only on that strobe. Configuration writes arrive as whole words. A unit accepts them only while it is disabled and after a short settling delay, which a write-allowed output reports. Software clears each flag with a strobe. Each flag, gated by its own interrupt enable, drives an interrupt line.

Top module: `cal_alarm_pair`

## Requirements
- R1: After reset every alarm flag and interrupt is 0, every write-allowed output is 1, and every stored configuration word is all zeros.
- R2: The time word uses these bit positions: second BCD [6:0], second mask 7, minute BCD [14:8], minute mask 15, hour BCD [21:16], PM bit 22, hour mask 23, day [29:24], weekday select 30, day mask 31. An unmasked field must equal the calendar field. A masked field (mask bit 1) always matches.
- R3: When weekday select is 1, day[2:0] is compared with the calendar weekday code (1 to 7, Monday to Sunday). When it is 0, the full 6-bit BCD day (01 to 31) is compared with the calendar date.
- R4: When hour12 is 0 the PM bit takes no part in the compare. When hour12 is 1, the stored PM bit must equal cal_pm for the hour field to match.
- R5: The sub-second word holds the value in [14:0] and a mask code n in [18:15]. Only bits [n-1:0] of cal_ssec are compared: n = 0 compares none, and n = 15 compares all 15 bits.
- R6: A flag can set only in a cycle where cal_tick and that unit's enable are both 1 and all fields match. It sets only on the first tick of a run of matching ticks. A run ends at a non-matching tick or when cal_sec differs from its value at the previous tick, so a unit with every field masked fires once per calendar second.
- R7: A flag stays at 1 until flag_clr for that unit is seen. When a set and a clear fall in the same cycle, the set wins.
- R8: alm_irq of a unit is 1 exactly when its flag is 1 and its irq_en is 1.
- R9: wr_ok of a unit is 0 while the unit is enabled. It returns to 1 exactly WR_OK_DLY clock cycles after the enable falls (default 2). Configuration writes made while wr_ok is 0 are dropped.
- R10: The two units are independent. Configuration, enable, clear and flag of one have no effect on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hour12 | input | 1 | 1 selects 12-hour compare with PM bit |
| cal_tick | input | 1 | Calendar update strobe, one cycle |
| cal_date | input | 6 | Calendar day of month, BCD |
| cal_wday | input | 3 | Calendar weekday code 1..7 |
| cal_hour | input | 6 | Calendar hour, BCD |
| cal_pm | input | 1 | Calendar PM indicator |
| cal_min | input | 7 | Calendar minute, BCD |
| cal_sec | input | 7 | Calendar second, BCD |
| cal_ssec | input | 15 | Sub-second down-counter |
| alm_en | input | NUM_ALARMS | Per-unit alarm enable |
| irq_en | input | NUM_ALARMS | Per-unit interrupt enable |
| flag_clr | input | NUM_ALARMS | Per-unit flag clear strobe |
| time_wr | input | NUM_ALARMS | Per-unit time word write strobe |
| ssec_wr | input | NUM_ALARMS | Per-unit sub-second word write strobe |
| time_wdata | input | 32 | Time word write data |
| ssec_wdata | input | 19 | Sub-second word write data |
| alm_flag | output | NUM_ALARMS | Sticky alarm flags |
| alm_irq | output | NUM_ALARMS | Interrupt lines |
| wr_ok | output | NUM_ALARMS | Configuration write allowed |

## Verification
The collision that matters most is a fresh match on a calendar tick that lands in the same cycle as a software clear of the same flag. The bench provokes it by asserting flag_clr together with a tick whose second has just changed and whose fields all match. It then expects the flag to read 1 in the following cycle, because a lost alarm would be the worse outcome. A second overlap is a configuration write issued in the same window as an enabled unit. The bench judges that case by showing that the old compare values still fire and the written ones do not take effect.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

  localparam int SSEC_W  = 15;
  localparam int NCODE_W = 4;
  localparam int TIME_W  = 32;
  localparam int SSCFG_W = SSEC_W + NCODE_W;

  // time word, MSB first
  typedef struct packed {
    logic       day_msk;
    logic       day_is_wday;
    logic [5:0] day;
    logic       hr_msk;
    logic       pm;
    logic [5:0] hour;
    logic       min_msk;
    logic [6:0] minute;
    logic       sec_msk;
    logic [6:0] second;
  } alm_time_t;

  typedef struct packed {
    logic [NCODE_W-1:0] ncode;
    logic [SSEC_W-1:0]  val;
  } alm_ssec_t;

  // bits of the sub-second counter that take part in the compare
  function automatic logic [SSEC_W-1:0] ssec_keep(input logic [NCODE_W-1:0] n);
    logic [SSEC_W:0] m;
    m = ({{SSEC_W{1'b0}}, 1'b1} << n) - {{SSEC_W{1'b0}}, 1'b1};
    return m[SSEC_W-1:0];
  endfunction

  function automatic logic ssec_equal(input logic [SSEC_W-1:0] a,
                                      input logic [SSEC_W-1:0] b,
                                      input logic [NCODE_W-1:0] n);
    return ((a ^ b) & ssec_keep(n)) == '0;
  endfunction

  function automatic logic day_equal(input alm_time_t t,
                                     input logic [5:0] date,
                                     input logic [2:0] wday);
    if (t.day_is_wday) return t.day[2:0] == wday;
    return t.day == date;
  endfunction

  function automatic logic hour_equal(input alm_time_t t,
                                      input logic [5:0] hour,
                                      input logic pm,
                                      input logic h12);
    return (t.hour == hour) && (!h12 || (t.pm == pm));
  endfunction

endpackage

// File: rtl/alarm_cfg_regs.sv
module alarm_cfg_regs
  import cal_alarm_pkg::*;
#(
  parameter int WR_OK_DLY = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                time_wr,
  input  logic                ssec_wr,
  input  logic [TIME_W-1:0]   time_din,
  input  logic [SSCFG_W-1:0]  ssec_din,
  output alm_time_t           time_q,
  output alm_ssec_t           ssec_q,
  output logic                wr_ok
);

  localparam int CW = $clog2(WR_OK_DLY + 1) < 1 ? 1 : $clog2(WR_OK_DLY + 1);
  localparam logic [CW-1:0] SETTLED = CW'(WR_OK_DLY);

  logic [CW-1:0] settle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 settle <= SETTLED;
    else if (en)                settle <= '0;
    else if (settle != SETTLED) settle <= settle + 1'b1;
  end

  assign wr_ok = !en && (settle == SETTLED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      ssec_q <= '0;
    end else if (wr_ok) begin
      if (time_wr) time_q <= alm_time_t'(time_din);
      if (ssec_wr) ssec_q <= alm_ssec_t'(ssec_din);
    end
  end

endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import cal_alarm_pkg::*;
(
  input  alm_time_t           cfg_t,
  input  alm_ssec_t           cfg_s,
  input  logic                hour12,
  input  logic [5:0]          cal_date,
  input  logic [2:0]          cal_wday,
  input  logic [5:0]          cal_hour,
  input  logic                cal_pm,
  input  logic [6:0]          cal_min,
  input  logic [6:0]          cal_sec,
  input  logic [SSEC_W-1:0]   cal_ssec,
  output logic [4:0]          field_hit,
  output logic                match
);

  always_comb begin
    field_hit[0] = cfg_t.sec_msk || (cfg_t.second == cal_sec);
    field_hit[1] = cfg_t.min_msk || (cfg_t.minute == cal_min);
    field_hit[2] = cfg_t.hr_msk  || hour_equal(cfg_t, cal_hour, cal_pm, hour12);
    field_hit[3] = cfg_t.day_msk || day_equal(cfg_t, cal_date, cal_wday);
    field_hit[4] = ssec_equal(cfg_s.val, cal_ssec, cfg_s.ncode);
  end

  assign match = &field_hit;

endmodule

// File: rtl/alarm_event.sv
module alarm_event (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       match,
  input  logic [6:0] sec_now,
  input  logic       clr,
  input  logic       irq_en,
  output logic       hit,
  output logic       flag,
  output logic       irq
);

  logic       prev_match;
  logic [6:0] prev_sec;
  logic       fresh;

  assign fresh = match && (!prev_match || (sec_now != prev_sec));
  assign hit   = tick && en && fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_match <= 1'b0;
      prev_sec   <= '0;
    end else if (tick) begin
      prev_match <= match;
      prev_sec   <= sec_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag && irq_en;

endmodule

// File: rtl/cal_alarm_pair.sv
module cal_alarm_pair
  import cal_alarm_pkg::*;
#(
  parameter int NUM_ALARMS = 2,
  parameter int WR_OK_DLY  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hour12,
  input  logic                   cal_tick,
  input  logic [5:0]             cal_date,
  input  logic [2:0]             cal_wday,
  input  logic [5:0]             cal_hour,
  input  logic                   cal_pm,
  input  logic [6:0]             cal_min,
  input  logic [6:0]             cal_sec,
  input  logic [14:0]            cal_ssec,
  input  logic [NUM_ALARMS-1:0]  alm_en,
  input  logic [NUM_ALARMS-1:0]  irq_en,
  input  logic [NUM_ALARMS-1:0]  flag_clr,
  input  logic [NUM_ALARMS-1:0]  time_wr,
  input  logic [NUM_ALARMS-1:0]  ssec_wr,
  input  logic [31:0]            time_wdata,
  input  logic [18:0]            ssec_wdata,
  output logic [NUM_ALARMS-1:0]  alm_flag,
  output logic [NUM_ALARMS-1:0]  alm_irq,
  output logic [NUM_ALARMS-1:0]  wr_ok
);

  logic [NUM_ALARMS-1:0] alm_hit;   // per-unit set event, visible to checker
  logic [NUM_ALARMS-1:0] alm_match; // per-unit compare result

  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alm
    alm_time_t  t_q;
    alm_ssec_t  s_q;
    logic [4:0] f_hit;

    alarm_cfg_regs #(.WR_OK_DLY(WR_OK_DLY)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (alm_en[g]),
      .time_wr  (time_wr[g]),
      .ssec_wr  (ssec_wr[g]),
      .time_din (time_wdata),
      .ssec_din (ssec_wdata),
      .time_q   (t_q),
      .ssec_q   (s_q),
      .wr_ok    (wr_ok[g])
    );

    alarm_match u_match (
      .cfg_t     (t_q),
      .cfg_s     (s_q),
      .hour12    (hour12),
      .cal_date  (cal_date),
      .cal_wday  (cal_wday),
      .cal_hour  (cal_hour),
      .cal_pm    (cal_pm),
      .cal_min   (cal_min),
      .cal_sec   (cal_sec),
      .cal_ssec  (cal_ssec),
      .field_hit (f_hit),
      .match     (alm_match[g])
    );

    alarm_event u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (cal_tick),
      .en      (alm_en[g]),
      .match   (alm_match[g]),
      .sec_now (cal_sec),
      .clr     (flag_clr[g]),
      .irq_en  (irq_en[g]),
      .hit     (alm_hit[g]),
      .flag    (alm_flag[g]),
      .irq     (alm_irq[g])
    );
  end

endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk #(
  parameter int N = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cal_tick,
  input logic [N-1:0] alm_en,
  input logic [N-1:0] irq_en,
  input logic [N-1:0] flag_clr,
  input logic [N-1:0] alm_hit,
  input logic [N-1:0] alm_flag,
  input logic [N-1:0] alm_irq,
  input logic [N-1:0] wr_ok
);

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_HIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      alm_hit[i] |-> (cal_tick && alm_en[i])); // R6
    AST_FLAG_RISE_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm_flag[i]) |-> $past(alm_hit[i])); // R6
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_flag[i] && !flag_clr[i]) |=> alm_flag[i]); // R7
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      alm_hit[i] |=> alm_flag[i]); // R7
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[i] && !alm_hit[i]) |=> !alm_flag[i]); // R7
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      alm_irq[i] |-> (alm_flag[i] && irq_en[i])); // R8
    AST_NO_WRITE_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      alm_en[i] |-> !wr_ok[i]); // R9
  end

endmodule

bind cal_alarm_pair cal_alarm_chk #(.N(NUM_ALARMS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cal_tick (cal_tick),
  .alm_en   (alm_en),
  .irq_en   (irq_en),
  .flag_clr (flag_clr),
  .alm_hit  (alm_hit),
  .alm_flag (alm_flag),
  .alm_irq  (alm_irq),
  .wr_ok    (wr_ok)
);

// File: tb/sim_cal_alarm_pair.sv
`timescale 1ns/1ps
module sim_cal_alarm_pair;

  localparam int DLY = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hour12 = 1'b0;
  logic        cal_tick = 1'b0;
  logic [5:0]  cal_date = 6'h01;
  logic [2:0]  cal_wday = 3'd1;
  logic [5:0]  cal_hour = 6'h00;
  logic        cal_pm = 1'b0;
  logic [6:0]  cal_min = 7'h00;
  logic [6:0]  cal_sec = 7'h00;
  logic [14:0] cal_ssec = 15'h0;
  logic [1:0]  alm_en = 2'b00;
  logic [1:0]  irq_en = 2'b00;
  logic [1:0]  flag_clr = 2'b00;
  logic [1:0]  time_wr = 2'b00;
  logic [1:0]  ssec_wr = 2'b00;
  logic [31:0] time_wdata = '0;
  logic [18:0] ssec_wdata = '0;
  logic [1:0]  alm_flag, alm_irq, wr_ok;

  int total = 0;
  int fails = 0;
  int sec_k = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cal_alarm_pair #(.NUM_ALARMS(2), .WR_OK_DLY(DLY)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] to_bcd(input int v);
    return 7'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [31:0] tword(input bit dm, input bit ws, input logic [5:0] d,
                                        input bit hm, input bit pm, input logic [5:0] h,
                                        input bit mm, input logic [6:0] m,
                                        input bit sm, input logic [6:0] s);
    return {dm, ws, d, hm, pm, h, mm, m, sm, s};
  endfunction

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic set_en(input int i, input bit v);
    alm_en[i] = v; cyc();
  endtask

  task automatic wr_time(input int i, input logic [31:0] w);
    time_wr[i] = 1'b1; time_wdata = w; cyc(); time_wr[i] = 1'b0;
  endtask

  task automatic wr_ssec(input int i, input logic [3:0] n, input logic [14:0] v);
    ssec_wr[i] = 1'b1; ssec_wdata = {n, v}; cyc(); ssec_wr[i] = 1'b0;
  endtask

  task automatic clr(input int i);
    flag_clr[i] = 1'b1; cyc(); flag_clr[i] = 1'b0;
  endtask

  // pulse the tick with the current calendar values
  task automatic tick();
    cal_tick = 1'b1; cyc(); cal_tick = 1'b0;
  endtask

  // tick with a new second so every tick starts a fresh run
  task automatic tick_fresh();
    sec_k = (sec_k + 1) % 60;
    cal_sec = to_bcd(sec_k);
    tick();
  endtask

  task automatic reconfig(input int i, input logic [31:0] w, input logic [3:0] n, input logic [14:0] v);
    set_en(i, 1'b0);
    repeat (DLY) cyc();
    wr_time(i, w);
    wr_ssec(i, n, v);
    set_en(i, 1'b1);
    clr(i);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] all_msk;
    logic [14:0] v;
    logic [14:0] probe [4];
    all_msk = tword(1, 0, 6'h0, 1, 0, 6'h0, 1, 7'h0, 1, 7'h0);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(alm_flag == 2'b00, "R1 flags", 32'(alm_flag), 0);
    chk(alm_irq == 2'b00, "R1 irq", 32'(alm_irq), 0);
    chk(wr_ok == 2'b11, "R1 wr_ok", 32'(wr_ok), 3);
    // R1 zero config: day 00 date, compare everything vs zero calendar
    cal_date = 6'h00; cal_wday = 3'd0; cal_sec = 7'h00;
    set_en(0, 1'b1);
    tick();
    chk(alm_flag[0] == 1'b1, "R1 zero config matches zero calendar", 32'(alm_flag[0]), 1);
    clr(0);
    cal_date = 6'h01; cal_wday = 3'd1;

    // R9 write-allowed timing
    chk(wr_ok[0] == 1'b0, "R9 wr_ok low while enabled", 32'(wr_ok[0]), 0);
    alm_en[0] = 1'b0;
    for (int c = 1; c <= DLY; c++) begin
      cyc();
      chk(wr_ok[0] == (c == DLY), "R9 wr_ok settle", 32'(wr_ok[0]), 32'(c == DLY));
    end

    // R5 sub-second mask sweep, all calendar fields masked
    for (int n = 0; n < 16; n++) begin
      v = 15'h5A5A;
      reconfig(0, all_msk, 4'(n), v);
      probe[0] = v;
      probe[1] = (n > 0) ? v ^ 15'(1 << (n - 1)) : v ^ 15'h7FFF;
      probe[2] = (n < 15) ? v ^ 15'(1 << n) : v ^ 15'h0001;
      probe[3] = v ^ 15'h7FFF;
      for (int p = 0; p < 4; p++) begin
        bit expm;
        cal_ssec = probe[p];
        expm = ((int'(probe[p]) % (1 << n)) == (int'(v) % (1 << n)));
        tick_fresh();
        chk(alm_flag[0] == expm, $sformatf("R5 n=%0d probe=%0h", n, probe[p]), 32'(alm_flag[0]), 32'(expm));
        clr(0);
      end
    end
    cal_ssec = '0;

    // R2 second sweep on unit 1, unit 0 disabled (R10)
    set_en(0, 1'b0);
    clr(0);
    reconfig(1, tword(1, 0, 6'h0, 1, 0, 6'h0, 1, 7'h0, 0, 7'h37), 4'd0, '0);
    for (int k = 0; k < 60; k++) begin
      cal_sec = to_bcd(k);
      tick();
      chk(alm_flag[1] == (k == 37), $sformatf("R2 second sweep k=%0d", k), 32'(alm_flag[1]), 32'(k == 37));
      chk(alm_flag[0] == 1'b0, "R10 other unit quiet", 32'(alm_flag[0]), 0);
      clr(1);
    end

    // R2 minute field
    reconfig(1, tword(1, 0, 6'h0, 1, 0, 6'h0, 0, 7'h42, 1, 7'h0), 4'd0, '0);
    for (int k = 40; k < 45; k++) begin
      cal_min = to_bcd(k);
      tick_fresh();
      chk(alm_flag[1] == (k == 42), $sformatf("R2 minute k=%0d", k), 32'(alm_flag[1]), 32'(k == 42));
      clr(1);
    end

    // R3 weekday mode
    reconfig(0, tword(0, 1, 6'h03, 1, 0, 6'h0, 1, 7'h0, 1, 7'h0), 4'd0, '0);
    cal_date = 6'h03;
    for (int w = 1; w <= 7; w++) begin
      cal_wday = 3'(w);
      tick_fresh();
      chk(alm_flag[0] == (w == 3), $sformatf("R3 weekday w=%0d", w), 32'(alm_flag[0]), 32'(w == 3));
      clr(0);
    end
    // R3 date mode
    reconfig(0, tword(0, 0, 6'h15, 1, 0, 6'h0, 1, 7'h0, 1, 7'h0), 4'd0, '0);
    cal_wday = 3'd5;
    for (int d = 1; d <= 31; d++) begin
      cal_date = 6'(to_bcd(d));
      tick_fresh();
      chk(alm_flag[0] == (d == 15), $sformatf("R3 date d=%0d", d), 32'(alm_flag[0]), 32'(d == 15));
      clr(0);
    end

    // R4 hour and PM
    reconfig(0, tword(1, 0, 6'h0, 0, 1, 6'h07, 1, 7'h0, 1, 7'h0), 4'd0, '0);
    cal_hour = 6'h07;
    for (int m = 0; m < 4; m++) begin
      bit expm;
      hour12 = m[1]; cal_pm = m[0];
      expm = !hour12 || cal_pm;
      tick_fresh();
      chk(alm_flag[0] == expm, $sformatf("R4 h12=%0d pm=%0d", hour12, cal_pm), 32'(alm_flag[0]), 32'(expm));
      clr(0);
    end
    cal_hour = 6'h08; hour12 = 1'b0;
    tick_fresh();
    chk(alm_flag[0] == 1'b0, "R4 wrong hour", 32'(alm_flag[0]), 0);

    // R6 run behaviour with all fields masked
    reconfig(0, all_msk, 4'd0, '0);
    tick_fresh();
    chk(alm_flag[0] == 1'b1, "R6 first tick of run", 32'(alm_flag[0]), 1);
    clr(0);
    tick(); tick();
    chk(alm_flag[0] == 1'b0, "R6 same second no refire", 32'(alm_flag[0]), 0);
    tick_fresh();
    chk(alm_flag[0] == 1'b1, "R6 new second refires", 32'(alm_flag[0]), 1);
    clr(0);
    // R6 disabled unit never sets
    set_en(0, 1'b0);
    tick_fresh();
    chk(alm_flag[0] == 1'b0, "R6 disabled no set", 32'(alm_flag[0]), 0);
    set_en(0, 1'b1);
    // R6 no set without tick
    sec_k = (sec_k + 1) % 60; cal_sec = to_bcd(sec_k);
    cyc();
    chk(alm_flag[0] == 1'b0, "R6 no tick no set", 32'(alm_flag[0]), 0);

    // R7 set wins over clear in the same cycle
    sec_k = (sec_k + 1) % 60; cal_sec = to_bcd(sec_k);
    cal_tick = 1'b1; flag_clr[0] = 1'b1;
    cyc();
    cal_tick = 1'b0; flag_clr[0] = 1'b0;
    chk(alm_flag[0] == 1'b1, "R7 set beats clear", 32'(alm_flag[0]), 1);
    repeat (3) cyc();
    chk(alm_flag[0] == 1'b1, "R7 sticky", 32'(alm_flag[0]), 1);

    // R8 interrupt gating
    irq_en[0] = 1'b0; cyc();
    chk(alm_irq[0] == 1'b0, "R8 irq masked", 32'(alm_irq[0]), 0);
    irq_en[0] = 1'b1; cyc();
    chk(alm_irq[0] == 1'b1, "R8 irq on", 32'(alm_irq[0]), 1);
    chk(alm_irq[1] == 1'b0, "R10 irq other unit", 32'(alm_irq[1]), 0);
    clr(0);
    chk(alm_flag[0] == 1'b0, "R7 clear", 32'(alm_flag[0]), 0);
    chk(alm_irq[0] == 1'b0, "R8 irq follows clear", 32'(alm_irq[0]), 0);

    // R9 write while enabled is dropped: unit 0 still all-masked
    wr_time(0, tword(1, 0, 6'h0, 1, 0, 6'h0, 1, 7'h0, 0, 7'h11));
    cal_sec = 7'h22; sec_k = 22;
    tick();
    chk(alm_flag[0] == 1'b1, "R9 write while enabled ignored", 32'(alm_flag[0]), 1);
    clr(0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule